// File: doc/BRIEF.md
# Flash Program-Verify Timing Sequencer

This block steps an embedded flash array through a single program pass followed by a program-verify pass. It drives four control levels: write enable, program setup, program pulse and verify mode. It also produces a one-cycle dummy-write strobe. Every set or clear edge on these levels is followed by a fixed minimum wait, counted in microseconds. The microsecond tick comes from the system clock through a cycles-per-microsecond parameter. Each wait is timed to the exact nominal number of clock cycles, so the program pulse lands inside its tolerance window for any integer clock ratio of one or more.

The host pulses a start input and chooses one of three pulse widths. When the sequence ends, the host reads a pass/fail flag and a one-cycle done strobe. The flag is taken from the verify-result input at one sampling point. Picking the next pulse width and retrying is left to the host. Each start runs exactly one pass.

Top module: `flash_pgm_seq`

## Requirements
- R1: While reset is asserted (rst_n low, including in the middle of a pass), wen_o, psetup_o, ppulse_o, vmode_o, dummy_wr_o, busy_o, done_o and pass_o are all 0. This takes effect at once, without a clock edge.
- R2: A start_i seen high in idle raises wen_o and busy_o on that same clock edge. psetup_o rises exactly 1 µs (CYC_PER_US cycles) after wen_o.
- R3: ppulse_o rises exactly 50 µs after psetup_o rises.
- R4: ppulse_o stays high for exactly 10, 30 or 200 µs when the latched width_sel_i is 2'b00, 2'b01 or 2'b10. The code 2'b11 gives 10 µs.
- R5: psetup_o falls exactly 5 µs after ppulse_o falls. vmode_o rises exactly 5 µs after psetup_o falls.
- R6: dummy_wr_o is high for exactly one cycle, 4 µs after vmode_o rises. vmode_o falls exactly 2 µs after dummy_wr_o rises.
- R7: wen_o falls exactly 2 µs after vmode_o falls. Exactly 100 µs after that, busy_o falls and done_o is high for one cycle.
- R8: start_i is ignored while busy_o is high. width_sel_i is latched when a start is accepted, and later changes have no effect on the pulse width.
- R9: pass_o takes the value of verify_ok_i on the clock edge where vmode_o falls. Later changes of verify_ok_i do not affect it.
- R10: pass_o clears when a start is accepted and holds its value after done_o until the next start.
- R11: ppulse_o is high only while psetup_o and wen_o are high. vmode_o is never high together with psetup_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe, sampled while idle |
| width_sel_i | input | 2 | Program pulse width code |
| verify_ok_i | input | 1 | Verify comparison result from the array |
| wen_o | output | 1 | Flash write enable |
| psetup_o | output | 1 | Program setup |
| ppulse_o | output | 1 | Program pulse |
| vmode_o | output | 1 | Program-verify mode |
| dummy_wr_o | output | 1 | One-cycle dummy write strobe in verify mode |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle end-of-pass strobe |
| pass_o | output | 1 | Verify result of the last pass |

## Verification
A wrong state or microsecond count shows up as an edge on one of the four control levels that arrives early or late. The error is visible in the cycle of that edge, one prescaler period or more away from the expected cycle. The bench timestamps every edge and checks each interval to the exact cycle, so a single-cycle slip anywhere in the chain is reported at that interval. A wrongly decoded state breaks the ordering of the levels in the cycle it is entered. A sampling error in the verify stage shows on pass_o at done_o.

// File: rtl/fps_pkg.sv
package fps_pkg;

  localparam int unsigned US_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WEN, ST_SETUP, ST_PULSE, ST_PCLR,
    ST_SCLR, ST_VSET, ST_VDUM, ST_VCLR, ST_WCLR
  } fps_state_e;

  localparam logic [US_W-1:0] T_WEN      = 8'd1;
  localparam logic [US_W-1:0] T_SETUP    = 8'd50;
  localparam logic [US_W-1:0] T_PCLR     = 8'd5;
  localparam logic [US_W-1:0] T_SCLR     = 8'd5;
  localparam logic [US_W-1:0] T_VSET     = 8'd4;
  localparam logic [US_W-1:0] T_VDUM     = 8'd2;
  localparam logic [US_W-1:0] T_VCLR     = 8'd2;
  localparam logic [US_W-1:0] T_WCLR     = 8'd100;
  localparam logic [US_W-1:0] T_PW_SHORT = 8'd10;
  localparam logic [US_W-1:0] T_PW_MID   = 8'd30;
  localparam logic [US_W-1:0] T_PW_LONG  = 8'd200;

  function automatic logic [US_W-1:0] pulse_us(input logic [1:0] sel);
    case (sel)
      2'b01:   pulse_us = T_PW_MID;
      2'b10:   pulse_us = T_PW_LONG;
      default: pulse_us = T_PW_SHORT;
    endcase
  endfunction

endpackage

// File: rtl/fps_tick_gen.sv
module fps_tick_gen #(
  parameter int unsigned CYC_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYC_PER_US - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == LAST);

  always_comb begin
    if (clr_i || tick_o) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);  // R2

endmodule

// File: rtl/fps_us_count.sv
module fps_us_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en   = load_i || (tick_i && (cnt_q != '0));
  assign expire_o = tick_i && (cnt_q == W'(1));

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q != '0));  // R3

endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [1:0]      sel_i,
  input  logic            verify_ok_i,
  input  logic            expire_i,
  output logic            load_o,
  output logic [US_W-1:0] load_val_o,
  output logic            wen_o,
  output logic            psetup_o,
  output logic            ppulse_o,
  output logic            vmode_o,
  output logic            dummy_wr_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            pass_o
);
  fps_state_e state_q, state_d;
  logic [1:0] sel_q, sel_d;
  logic       pass_q, pass_d;
  logic       dummy_q, dummy_d;
  logic       done_q, done_d;

  always_comb begin
    state_d    = state_q;
    sel_d      = sel_q;
    pass_d     = pass_q;
    dummy_d    = 1'b0;
    done_d     = 1'b0;
    load_o     = 1'b0;
    load_val_o = '0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_WEN;  load_o = 1'b1; load_val_o = T_WEN;
        sel_d   = sel_i;   pass_d = 1'b0;
      end
      ST_WEN: if (expire_i) begin
        state_d = ST_SETUP; load_o = 1'b1; load_val_o = T_SETUP;
      end
      ST_SETUP: if (expire_i) begin
        state_d = ST_PULSE; load_o = 1'b1; load_val_o = pulse_us(sel_q);
      end
      ST_PULSE: if (expire_i) begin
        state_d = ST_PCLR; load_o = 1'b1; load_val_o = T_PCLR;
      end
      ST_PCLR: if (expire_i) begin
        state_d = ST_SCLR; load_o = 1'b1; load_val_o = T_SCLR;
      end
      ST_SCLR: if (expire_i) begin
        state_d = ST_VSET; load_o = 1'b1; load_val_o = T_VSET;
      end
      ST_VSET: if (expire_i) begin
        state_d = ST_VDUM; load_o = 1'b1; load_val_o = T_VDUM;
        dummy_d = 1'b1;
      end
      ST_VDUM: if (expire_i) begin
        state_d = ST_VCLR; load_o = 1'b1; load_val_o = T_VCLR;
        pass_d  = verify_ok_i;
      end
      ST_VCLR: if (expire_i) begin
        state_d = ST_WCLR; load_o = 1'b1; load_val_o = T_WCLR;
      end
      ST_WCLR: if (expire_i) begin
        state_d = ST_IDLE; done_d = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 2'b00;
      pass_q  <= 1'b0;
      dummy_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      pass_q  <= pass_d;
      dummy_q <= dummy_d;
      done_q  <= done_d;
    end
  end

  assign wen_o      = !(state_q inside {ST_IDLE, ST_WCLR});
  assign psetup_o   = state_q inside {ST_SETUP, ST_PULSE, ST_PCLR};
  assign ppulse_o   = (state_q == ST_PULSE);
  assign vmode_o    = state_q inside {ST_VSET, ST_VDUM};
  assign busy_o     = (state_q != ST_IDLE);
  assign dummy_wr_o = dummy_q;
  assign done_o     = done_q;
  assign pass_o     = pass_q;

  AST_PULSE_NEEDS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    ppulse_o |-> (psetup_o && wen_o));  // R11
  AST_VERIFY_EXCL_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    vmode_o |-> !psetup_o);  // R11
  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ppulse_o && !expire_i) |=> ppulse_o);  // R4
  AST_DUMMY_IN_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_wr_o |-> vmode_o);  // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R7
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(sel_q));  // R8
  AST_PASS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_VDUM && !(state_q == ST_IDLE && start_i)) |=> $stable(pass_o));  // R10

endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq
  import fps_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] width_sel_i,
  input  logic       verify_ok_i,
  output logic       wen_o,
  output logic       psetup_o,
  output logic       ppulse_o,
  output logic       vmode_o,
  output logic       dummy_wr_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       pass_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            tick;
  logic            expire;
  logic            load;
  logic [US_W-1:0] load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fps_tick_gen #(.CYC_PER_US(CYC_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .clr_i(load), .tick_o(tick)
  );

  fps_us_count #(.W(US_W)) u_count (
    .clk(clk), .rst_n(rst_int_n), .load_i(load), .load_val_i(load_val),
    .tick_i(tick), .expire_o(expire)
  );

  fps_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start_i(start_i), .sel_i(width_sel_i),
    .verify_ok_i(verify_ok_i), .expire_i(expire), .load_o(load),
    .load_val_o(load_val), .wen_o(wen_o), .psetup_o(psetup_o),
    .ppulse_o(ppulse_o), .vmode_o(vmode_o), .dummy_wr_o(dummy_wr_o),
    .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o)
  );

endmodule

// File: tb/flash_pgm_seq_tb.sv
module flash_pgm_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int C = 3;

  typedef struct packed {
    logic [1:0] sel;
    logic       vok;
    logic [7:0] pw_us;
    logic       disturb;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 8'd10,  1'b0},
    '{2'd1, 1'b0, 8'd30,  1'b0},
    '{2'd2, 1'b1, 8'd200, 1'b0},
    '{2'd3, 1'b1, 8'd10,  1'b0},
    '{2'd2, 1'b0, 8'd200, 1'b1},
    '{2'd1, 1'b1, 8'd30,  1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] width_sel = 2'b00;
  logic verify_ok = 1'b0;
  logic wen_o, psetup_o, ppulse_o, vmode_o, dummy_wr_o, busy_o, done_o, pass_o;
  longint cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_pgm_seq #(.CYC_PER_US(C)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .width_sel_i(width_sel),
    .verify_ok_i(verify_ok), .wen_o(wen_o), .psetup_o(psetup_o),
    .ppulse_o(ppulse_o), .vmode_o(vmode_o), .dummy_wr_o(dummy_wr_o),
    .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(req, {wen_o, psetup_o, ppulse_o, vmode_o, dummy_wr_o, busy_o, done_o}, 0);
  endtask

  task automatic run_pass(input vec_t v);
    longint t_st, t_wr, t_sr, t_pr, t_pf, t_sf, t_vr, t_dw, t_vf, t_wf, t_dn;
    int dw_cnt, n;
    logic pw, ps, pp, vm;
    t_wr = -1; t_sr = -1; t_pr = -1; t_pf = -1; t_sf = -1;
    t_vr = -1; t_dw = -1; t_vf = -1; t_wf = -1; t_dn = -1;
    dw_cnt = 0; n = 0;
    @(negedge clk);
    width_sel = v.sel; verify_ok = v.vok; start = 1'b1; t_st = cyc;
    pw = wen_o; ps = psetup_o; pp = ppulse_o; vm = vmode_o;
    while (!done_o && n < 5000) begin
      @(negedge clk);
      n++;
      if (wen_o && !pw) t_wr = cyc;
      if (!wen_o && pw) t_wf = cyc;
      if (psetup_o && !ps) t_sr = cyc;
      if (!psetup_o && ps) t_sf = cyc;
      if (ppulse_o && !pp) t_pr = cyc;
      if (!ppulse_o && pp) t_pf = cyc;
      if (vmode_o && !vm) t_vr = cyc;
      if (!vmode_o && vm) t_vf = cyc;
      if (dummy_wr_o) begin dw_cnt++; if (t_dw < 0) t_dw = cyc; end
      if (done_o) t_dn = cyc;
      if (n == 1) begin
        check("R10 pass cleared at start", pass_o, 0);
        check("R2 busy at start", busy_o, 1);
      end
      pw = wen_o; ps = psetup_o; pp = ppulse_o; vm = vmode_o;
      start = v.disturb && ppulse_o;
      if (v.disturb) width_sel = v.sel ^ 2'b11;
      if (v.disturb && t_vf >= 0) verify_ok = !v.vok;
    end
    start = 1'b0;
    check("R7 pass completes", (n < 5000), 1);
    check("R2 wen on start edge", t_wr - t_st, 1);
    check("R2 setup after wen", t_sr - t_wr, C);
    check("R3 pulse after setup", t_pr - t_sr, 50 * C);
    check("R4 R8 pulse width", t_pf - t_pr, v.pw_us * C);
    check("R5 setup clear after pulse", t_sf - t_pf, 5 * C);
    check("R5 verify after setup clear", t_vr - t_sf, 5 * C);
    check("R6 dummy after verify set", t_dw - t_vr, 4 * C);
    check("R6 dummy one cycle", dw_cnt, 1);
    check("R6 verify clear after dummy", t_vf - t_dw, 2 * C);
    check("R7 wen clear after verify", t_wf - t_vf, 2 * C);
    check("R7 done after wen clear", t_dn - t_wf, 100 * C);
    check("R7 busy low at done", busy_o, 0);
    check("R9 pass value", pass_o, v.vok);
    @(negedge clk);
    check("R7 done one cycle", done_o, 0);
    check("R10 pass held", pass_o, v.vok);
    verify_ok = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 reset outputs");
    check("R1 reset pass", pass_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 idle after release");

    for (int i = 0; i < NV; i++) run_pass(VECS[i]);

    // R1: reset in the middle of a pass clears outputs without a clock edge
    @(negedge clk);
    width_sel = 2'b10; verify_ok = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60 * C) @(negedge clk);
    check("R1 pulse active before reset", ppulse_o, 1);
    #1 rst_n = 1'b0;
    #1 check_idle("R1 async reset mid-pass");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 idle after mid-pass reset");
    check("R1 pass after reset", pass_o, 0);

    run_pass(VECS[0]);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule